// File: doc/BRIEF.md
# Low-Window Expansion Memory Pager

This block decides which memory answers the CPU in the lowest 16 KB of its address space. Three sources are possible: the host system ROM, an 8 KB expansion ROM, or one of four 8 KB expansion RAM banks. The block drives chip selects and write enables for the expansion memories. It also drives a disable line that takes the host ROM off the bus whenever expansion memory owns the access.

Software sets the mode through a write-only control byte on I/O port 0xE3. Bit 7 is a force-map bit. Bit 6 is a RAM-as-ROM bit, which software can only set and which only power-on clears. Bits 1..0 select a bank. Three sources decide the mode, in rising priority: the ROM jumper input, the RAM-as-ROM bit, and the force-map bit. The chosen mode sets both what appears in 0x0000–0x1FFF and whether that window can be written. Outside force-map, the automap flag from a neighbouring detector enables the mapping.

Top module: `mem_pager`

## Requirements
- R1: Power-on reset (por_n low) clears the force-map bit, the RAM-as-ROM bit and the bank field. After reset, an access at 0x2000 with automap active and the jumper closed selects RAM bank 0.
- R2: The control byte is written on a clock edge only when iorq_n and wr_n are low and cpu_addr[7:0] is 0xE3. cpu_addr[15:8] is a don't-care. Writes to any other port leave the mode unchanged.
- R3: RAM-as-ROM (data bit 6) is sticky. Writing 0 to that bit does not clear it, and only por_n clears it.
- R4: With force-map (bit 7) set, 0x0000–0x1FFF selects the expansion ROM. xrom_we follows wr_n only when rom_jmp is 0 (jumper open).
- R5: With force-map set, 0x2000–0x3FFF selects the RAM bank given by bits 1..0 on xram_bank, and that bank is always writable.
- R6: With force-map clear, RAM-as-ROM set and automap high, 0x0000–0x1FFF selects RAM with xram_bank = 3 and xram_we held low.
- R7: In the mode of R6, 0x2000–0x3FFF selects the chosen bank. It is writable unless the chosen bank is 3.
- R8: With both bits clear, rom_jmp = 1 (closed) and automap high, 0x0000–0x1FFF selects the expansion ROM with no write enable. 0x2000–0x3FFF selects the chosen bank, writable.
- R9: In every other case, and for any address at or above 0x4000, no expansion memory is selected and host_rom_dis is low.
- R10: host_rom_dis is high exactly when a mapping mode is active and the address is below 0x4000, whatever the strobes.
- R11: Selects need mreq_n low together with rd_n or wr_n low, so a refresh cycle (mreq_n low, both strobes high) selects nothing. Write enables need wr_n low.
- R12: Data bits 5..2 of the control byte have no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples control port writes |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus (control byte on port writes) |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rom_jmp | input | 1 | ROM jumper: 1 closed (ROM present, protected), 0 open |
| automap | input | 1 | Mapping request from the automap detector |
| host_rom_dis | output | 1 | Disables the host ROM |
| xrom_sel | output | 1 | Expansion ROM select |
| xrom_we | output | 1 | Expansion ROM write enable |
| xram_sel | output | 1 | Expansion RAM select |
| xram_bank | output | 2 | Expansion RAM bank address |
| xram_we | output | 1 | Expansion RAM write enable |

## Verification
Random control bytes, jumper and automap levels are mixed with reads, writes and refresh cycles over the whole address range. Each access is compared against a bench model of the priority order, so every mode is tried against both windows and the region above 0x4000. Directed cases cover the cases that random traffic rarely reaches. Mirrored and foreign port writes show that only the low address byte decodes. A zero written over the sticky bit shows that only power-on clears it. Bank 3 in the upper window under RAM-as-ROM shows the protection rule, and the jumper under force-map shows that it only gates ROM writes.

// File: rtl/mem_pager_pkg.sv
package mem_pager_pkg;

  localparam int ADDR_W  = 16;
  localparam int BANK_W  = 2;
  localparam int WIN_SZ  = 'h2000;
  localparam logic [7:0] CTRL_PORT = 8'hE3;
  localparam int FORCE_BIT  = 7;
  localparam int RAMROM_BIT = 6;
  localparam logic [BANK_W-1:0] PROT_BANK = '1;

  typedef enum logic [1:0] {
    MODE_NONE   = 2'd0,
    MODE_ROMMAP = 2'd1,
    MODE_RAMROM = 2'd2,
    MODE_FORCE  = 2'd3
  } map_mode_e;

  typedef struct packed {
    logic              force_map;
    logic              ram_rom;
    logic [BANK_W-1:0] bank;
  } ctrl_t;

  function automatic map_mode_e pick_mode(ctrl_t c, logic jmp, logic am);
    if (c.force_map)          return MODE_FORCE;
    else if (c.ram_rom && am) return MODE_RAMROM;
    else if (jmp && am)       return MODE_ROMMAP;
    else                      return MODE_NONE;
  endfunction

  function automatic logic in_low(logic [ADDR_W-1:0] a);
    return a < ADDR_W'(WIN_SZ);
  endfunction

  function automatic logic in_high(logic [ADDR_W-1:0] a);
    return (a >= ADDR_W'(WIN_SZ)) && (a < ADDR_W'(2 * WIN_SZ));
  endfunction

endpackage

// File: rtl/mem_pager_ctrl.sv
module mem_pager_ctrl
  import mem_pager_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              port_wr,
  input  logic [7:0]        wdata,
  output ctrl_t             ctrl
);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctrl <= '0;
    end else if (port_wr) begin
      ctrl.force_map <= wdata[FORCE_BIT];
      ctrl.ram_rom   <= ctrl.ram_rom | wdata[RAMROM_BIT];
      ctrl.bank      <= wdata[BANK_W-1:0];
    end
  end

  // R3: once set, RAM-as-ROM survives any write
  a_r3_ramrom_sticky: assert property (@(posedge clk) disable iff (!por_n)
    $past(ctrl.ram_rom) |-> ctrl.ram_rom);

  // R2: without a port write, the register holds
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!por_n)
    !$past(port_wr) |-> ($stable(ctrl.force_map) && $stable(ctrl.bank)));

endmodule

// File: rtl/mem_pager_decode.sv
module mem_pager_decode
  import mem_pager_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              rom_jmp,
  input  logic              automap,
  output logic              host_rom_dis,
  output logic              xrom_sel,
  output logic              xrom_we,
  output logic              xram_sel,
  output logic [BANK_W-1:0] xram_bank,
  output logic              xram_we
);

  map_mode_e mode;
  logic      lo_win, hi_win, strobe, wstrobe, mapped;

  assign mode    = pick_mode(ctrl, rom_jmp, automap);
  assign lo_win  = in_low(addr);
  assign hi_win  = in_high(addr);
  assign strobe  = !mreq_n && (!rd_n || !wr_n);
  assign wstrobe = !mreq_n && !wr_n;
  assign mapped  = (mode != MODE_NONE);

  always_comb begin
    host_rom_dis = mapped && (lo_win || hi_win);
    xrom_sel  = 1'b0;
    xrom_we   = 1'b0;
    xram_sel  = 1'b0;
    xram_we   = 1'b0;
    xram_bank = ctrl.bank;
    if (mapped && lo_win) begin
      unique case (mode)
        MODE_FORCE: begin
          xrom_sel = strobe;
          xrom_we  = wstrobe && !rom_jmp;
        end
        MODE_RAMROM: begin
          xram_sel  = strobe;
          xram_bank = PROT_BANK;
        end
        default: xrom_sel = strobe;
      endcase
    end else if (mapped && hi_win) begin
      xram_sel = strobe;
      xram_we  = wstrobe && !((mode == MODE_RAMROM) && (ctrl.bank == PROT_BANK));
    end
  end

  // R9/R4: ROM and RAM never selected together
  a_r9_single_select: assert property (@(posedge clk) disable iff (!por_n)
    !(xrom_sel && xram_sel));

  // R11: refresh cycle selects nothing
  a_r11_refresh_idle: assert property (@(posedge clk) disable iff (!por_n)
    (!mreq_n && rd_n && wr_n) |-> (!xrom_sel && !xram_sel));

  // R6: RAM in the low window is bank 3 and read-only
  a_r6_low_ram_protected: assert property (@(posedge clk) disable iff (!por_n)
    (xram_sel && lo_win) |-> (!xram_we && xram_bank == PROT_BANK));

  // R10: any expansion select implies the host ROM is off
  a_r10_host_off: assert property (@(posedge clk) disable iff (!por_n)
    (xrom_sel || xram_sel) |-> host_rom_dis);

  // R11: write enables only under a write strobe
  a_r11_we_needs_wr: assert property (@(posedge clk) disable iff (!por_n)
    (xrom_we || xram_we) |-> (!wr_n && !mreq_n));

endmodule

// File: rtl/mem_pager.sv
module mem_pager
  import mem_pager_pkg::*;
(
  input  logic        clk,
  input  logic        por_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic        mreq_n,
  input  logic        iorq_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic        rom_jmp,
  input  logic        automap,
  output logic        host_rom_dis,
  output logic        xrom_sel,
  output logic        xrom_we,
  output logic        xram_sel,
  output logic [1:0]  xram_bank,
  output logic        xram_we
);

  logic  port_wr;
  ctrl_t ctrl;

  assign port_wr = !iorq_n && !wr_n && (cpu_addr[7:0] == CTRL_PORT);

  mem_pager_ctrl u_ctrl (
    .clk     (clk),
    .por_n   (por_n),
    .port_wr (port_wr),
    .wdata   (cpu_data),
    .ctrl    (ctrl)
  );

  mem_pager_decode u_dec (
    .clk          (clk),
    .por_n        (por_n),
    .ctrl         (ctrl),
    .addr         (cpu_addr),
    .mreq_n       (mreq_n),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .rom_jmp      (rom_jmp),
    .automap      (automap),
    .host_rom_dis (host_rom_dis),
    .xrom_sel     (xrom_sel),
    .xrom_we      (xrom_we),
    .xram_sel     (xram_sel),
    .xram_bank    (xram_bank),
    .xram_we      (xram_we)
  );

endmodule

// File: tb/mem_pager_test.sv
module mem_pager_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        por_n = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        mreq_n = 1, iorq_n = 1, rd_n = 1, wr_n = 1;
  logic        rom_jmp = 0, automap = 0;
  logic        host_rom_dis, xrom_sel, xrom_we, xram_sel, xram_we;
  logic [1:0]  xram_bank;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  logic m_force = 0, m_rr = 0;
  logic [1:0] m_bank = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_pager uut (
    .clk(clk), .por_n(por_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .rom_jmp(rom_jmp), .automap(automap), .host_rom_dis(host_rom_dis),
    .xrom_sel(xrom_sel), .xrom_we(xrom_we), .xram_sel(xram_sel),
    .xram_bank(xram_bank), .xram_we(xram_we)
  );

  // expected {hdis, rsel, rwe, msel, bank[1:0], mwe}
  function automatic logic [6:0] model(logic [15:0] a, logic mq, logic rd, logic wr,
                                       logic jmp, logic am);
    logic lo, hi, acc, wa, hd, rs, rw, ms, mw;
    logic [1:0] bk;
    lo = (a <= 16'h1FFF);
    hi = (a >= 16'h2000) && (a <= 16'h3FFF);
    acc = !mq && (!rd || !wr);
    wa  = !mq && !wr;
    hd = 0; rs = 0; rw = 0; ms = 0; mw = 0; bk = m_bank;
    if (m_force) begin
      hd = lo || hi;
      if (lo) begin rs = acc; rw = wa && (jmp == 1'b0); end
      if (hi) begin ms = acc; mw = wa; end
    end else if (m_rr && am) begin
      hd = lo || hi;
      if (lo) begin ms = acc; bk = 2'd3; end
      if (hi) begin ms = acc; mw = wa && (m_bank != 2'd3); end
    end else if (jmp && am) begin
      hd = lo || hi;
      if (lo) rs = acc;
      if (hi) begin ms = acc; mw = wa; end
    end
    return {hd, rs, rw, ms, bk, mw};
  endfunction

  function automatic string tag_of(logic [15:0] a, logic jmp, logic am);
    if (a >= 16'h4000)         return "R9";
    if (m_force)               return (a < 16'h2000) ? "R4" : "R5";
    if (m_rr && am)            return (a < 16'h2000) ? "R6" : "R7";
    if (jmp && am)             return "R8";
    return "R9";
  endfunction

  task automatic compare(string tag);
    logic [6:0] exp, act;
    exp = model(cpu_addr, mreq_n, rd_n, wr_n, rom_jmp, automap);
    act = {host_rom_dis, xrom_sel, xrom_we, xram_sel, xram_bank, xram_we};
    if (!exp[3]) begin exp[2:1] = 2'b00; act[2:1] = 2'b00; end
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h mq=%b rd=%b wr=%b jmp=%b am=%b actual=%b expected=%b",
               tag, cpu_addr, mreq_n, rd_n, wr_n, rom_jmp, automap, act, exp);
    end
  endtask

  // kind: 0 read, 1 write, 2 refresh
  task automatic mem_access(logic [15:0] a, int kind, logic jmp, logic am, string tag);
    @(negedge clk);
    cpu_addr = a; iorq_n = 1; rom_jmp = jmp; automap = am;
    mreq_n = 0; rd_n = (kind != 0); wr_n = (kind != 1);
    #1;
    compare(tag.len() == 0 ? tag_of(a, jmp, am) : tag);
    @(negedge clk);
    mreq_n = 1; rd_n = 1; wr_n = 1;
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; mreq_n = 1; iorq_n = 0; wr_n = 0;
    @(negedge clk);
    iorq_n = 1; wr_n = 1;
    if (a[7:0] == 8'hE3) begin
      m_force = d[7]; m_rr = m_rr | d[6]; m_bank = d[1:0];
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    por_n = 1;
    // R1: reset state
    mem_access(16'h0100, 0, 1'b0, 1'b1, "R1");
    mem_access(16'h2345, 1, 1'b1, 1'b1, "R1");
    mem_access(16'h0000, 0, 1'b1, 1'b1, "R1");
    // R2: foreign port ignored; mirrored high byte accepted
    io_write(16'h00E7, 8'h80);
    mem_access(16'h0010, 0, 1'b0, 1'b0, "R2");
    io_write(16'h5AE3, 8'h82);
    mem_access(16'h0010, 1, 1'b0, 1'b0, "R2");
    mem_access(16'h3000, 1, 1'b1, 1'b0, "R2");
    // R4: jumper gates ROM write only under force-map
    mem_access(16'h1FFF, 1, 1'b1, 1'b0, "R4");
    mem_access(16'h1FFF, 1, 1'b0, 1'b1, "R4");
    // R5
    mem_access(16'h2000, 1, 1'b1, 1'b1, "R5");
    // R12: reserved bits ignored
    io_write(16'h00E3, 8'h3C);
    mem_access(16'h0000, 0, 1'b0, 1'b1, "R12");
    mem_access(16'h2800, 1, 1'b1, 1'b1, "R12");
    // R6/R7
    io_write(16'h00E3, 8'h43);
    mem_access(16'h0038, 1, 1'b1, 1'b1, "R6");
    mem_access(16'h3FFF, 1, 1'b1, 1'b1, "R7");
    io_write(16'h00E3, 8'h01);
    mem_access(16'h3FFF, 1, 1'b1, 1'b1, "R7");
    // R3: sticky bit stays after writing zero
    io_write(16'h00E3, 8'h00);
    mem_access(16'h0066, 0, 1'b1, 1'b1, "R3");
    mem_access(16'h0066, 0, 1'b1, 1'b0, "R3");
    // R11: refresh selects nothing
    mem_access(16'h0038, 2, 1'b1, 1'b1, "R11");
    mem_access(16'h4000, 1, 1'b1, 1'b1, "R9");
    // R8: fresh power-on clears sticky bit
    @(negedge clk); por_n = 0; m_force = 0; m_rr = 0; m_bank = 0;
    @(negedge clk); por_n = 1;
    mem_access(16'h0562, 1, 1'b1, 1'b1, "R8");
    mem_access(16'h3D00, 1, 1'b1, 1'b1, "R8");
    mem_access(16'h0562, 0, 1'b0, 1'b1, "R9");
    // random phase: R10 host disable checked on every access
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 8) == 0) begin
        logic [7:0] d;
        d = 8'($urandom);
        if (($urandom % 4) != 0) d[6] = 1'b0;
        io_write({8'($urandom), (($urandom % 4) == 0) ? 8'($urandom) : 8'hE3}, d);
      end else if (($urandom % 200) == 0) begin
        @(negedge clk); por_n = 0; m_force = 0; m_rr = 0; m_bank = 0;
        @(negedge clk); por_n = 1;
      end else begin
        logic [15:0] a;
        a = 16'($urandom);
        if (($urandom % 4) != 0) a[15:14] = 2'b00;
        mem_access(a, int'($urandom % 3), 1'($urandom), 1'($urandom), "");
      end
    end
    finish_run();
  end

endmodule